// File: doc/BRIEF.md
# Periodic Converter Trigger and Serial Result Reader

This block sits on the host side of an 18-bit serial analog-to-digital converter that runs as a slave. A free-running timer sets the sample rate. On each timer expiry the block drives a short convert-start pulse and then watches the converter's busy line. When busy falls, the conversion is over. The block then selects the converter and clocks in a fixed 24-bit frame as an SPI master in mode 1: the clock idles low, the converter shifts on the rising edge and the host samples on the falling edge. The first 18 bits received, MSB first, form the result.

The result is given to the rest of the chip as a one-cycle valid strobe with the word right-aligned. An interrupt strobe can be enabled at build time. A timer expiry that comes while a conversion or read is still running is dropped and counted. The serial clock comes from the system clock. Its half period is the requested divider, raised when needed so that the clock never runs faster than the converter's maximum serial rate.

Top module: `conv_readout_seq`

## Requirements
- R1: While reset is asserted, csN is high, sclk is low, convStart is low, sampleValid and irqStrobe are low and overrunCount is zero.
- R2: With the sequencer idle, a timer expiry produces a convStart pulse exactly CONV_PULSE_W cycles wide. Expiries are TIMER_PERIOD cycles apart, counted from the release of reset.
- R3: A falling edge on busyIn while no conversion is pending is ignored: csN stays high and no result is produced.
- R4: sclk is low whenever csN is high. Each sclk high and low phase lasts the effective half period, which is the larger of SCLK_HALF_REQ and ceil(SYS_CLK_HZ / (2*SCLK_MAX_HZ)). That is 3 cycles with the defaults.
- R5: Each read has exactly 24 rising sclk edges. The first rises one half period after csN falls.
- R6: misoIn is sampled on falling sclk edges. The first bit received is bit 17 of sampleData and the 18th is bit 0. The 6 bits received after those have no effect on the result.
- R7: csN rises one half period after the 24th falling sclk edge.
- R8: sampleValid is high for exactly one cycle, the cycle after csN rises, with sampleData valid. When IRQ_ENABLE is 1, irqStrobe is high in that same cycle.
- R9: A timer expiry that comes while the sequencer is busy gives no convStart and raises overrunCount by one, saturating at its maximum value. The next conversion starts on the following expiry.
- R10: busyIn goes through two synchronising flip-flops. csN falls on the third rising clock edge after busyIn falls at the end of a pending conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| busyIn | input | 1 | Converter busy line, asynchronous |
| misoIn | input | 1 | Serial data from the converter |
| convStart | output | 1 | Convert-start pulse, active high |
| csN | output | 1 | Converter select, active low |
| sclk | output | 1 | Serial clock, idles low |
| sampleValid | output | 1 | One-cycle strobe for a new result |
| sampleData | output | DATA_W | Result, right-aligned |
| irqStrobe | output | 1 | Interrupt strobe, follows sampleValid when enabled |
| overrunCount | output | OVR_W | Number of dropped timer expiries, saturating |

## Verification
The bench models the converter. Each frame carries trailing bits that differ from the result, so a design that kept the wrong 18 bits, sampled on the rising edge or shifted LSB first would return a wrong word. It measures the spacing from busy falling to csN falling, from csN to the first edge, every sclk phase width and the tail before csN rises. A missing synchroniser stage, an extra divider cycle or a clock faster than the cap would each shift one of those counts. It pulses busy while idle to catch a sequencer that reads on any busy edge. A long conversion that spans a timer expiry must raise the overrun count once and double the spacing to the next convert pulse, which a design that queued or restarted on that expiry would not do.

// File: rtl/seq_pkg.sv
package seq_pkg;

  typedef struct packed {
    logic clear;   // return the shifter and clock to idle
    logic clkEn;   // allow serial clock toggles
    logic runDiv;  // run the half-period divider
    logic publish; // move the received word to the output
  } dpCtrl_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CONV,
    S_WAIT,
    S_SHIFT,
    S_TAIL,
    S_DONE
  } seqState_t;

endpackage

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import seq_pkg::*;
#(
  parameter int TIMER_PERIOD = 1000,
  parameter int CONV_PULSE_W = 2,
  parameter int OVR_W        = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busyIn,
  input  logic             halfTick,
  input  logic             lastFall,
  output logic             convStart,
  output logic             csN,
  output dpCtrl_t          strobes,
  output logic [OVR_W-1:0] overrunCount
);

  localparam int TMR_W  = $clog2(TIMER_PERIOD + 1);
  localparam int CONV_W = $clog2(CONV_PULSE_W + 1);

  seqState_t         state, nextState;
  logic [TMR_W-1:0]  tmrCnt;
  logic [CONV_W-1:0] convCnt;
  logic              tick;
  logic              busyS1, busyS2, busyS3;
  logic              busyFall;

  // periodic timer
  assign tick = (tmrCnt == TMR_W'(TIMER_PERIOD - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    tmrCnt <= '0;
    else if (tick) tmrCnt <= '0;
    else           tmrCnt <= tmrCnt + 1'b1;
  end

  // two-stage synchroniser plus one stage for edge detect
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busyS1 <= 1'b0;
      busyS2 <= 1'b0;
      busyS3 <= 1'b0;
    end else begin
      busyS1 <= busyIn;
      busyS2 <= busyS1;
      busyS3 <= busyS2;
    end
  end

  assign busyFall = busyS3 & ~busyS2;

  always_comb begin
    nextState = state;
    unique case (state)
      S_IDLE:  if (tick) nextState = S_CONV;
      S_CONV:  if (convCnt == CONV_W'(CONV_PULSE_W - 1)) nextState = S_WAIT;
      S_WAIT:  if (busyFall) nextState = S_SHIFT;
      S_SHIFT: if (lastFall) nextState = S_TAIL;
      S_TAIL:  if (halfTick) nextState = S_DONE;
      S_DONE:  nextState = S_IDLE;
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      convCnt   <= '0;
      convStart <= 1'b0;
      csN       <= 1'b1;
    end else begin
      state     <= nextState;
      convCnt   <= (state == S_CONV) ? convCnt + 1'b1 : '0;
      convStart <= (nextState == S_CONV);
      csN       <= !(nextState == S_SHIFT || nextState == S_TAIL);
    end
  end

  // expiries that find the sequencer occupied
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      overrunCount <= '0;
    else if (tick && state != S_IDLE && overrunCount != {OVR_W{1'b1}})
      overrunCount <= overrunCount + 1'b1;
  end

  always_comb begin
    strobes.clear   = (state == S_IDLE) || (state == S_WAIT);
    strobes.clkEn   = (state == S_SHIFT);
    strobes.runDiv  = (state == S_SHIFT) || (state == S_TAIL);
    strobes.publish = (state == S_DONE);
  end

  // R10: select only follows a synchronised busy fall
  p_cs_after_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(csN) |-> $past(busyFall));

  // R9: overrun count never goes backwards
  p_overrun_mono_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> overrunCount >= $past(overrunCount));

  // R2: convert pulse never overlaps an active read
  p_conv_no_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    convStart |-> csN);

endmodule

// File: rtl/seq_datapath.sv
module seq_datapath
  import seq_pkg::*;
#(
  parameter int XFER_BITS = 24,
  parameter int DATA_W    = 18,
  parameter int HALF      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dpCtrl_t           strobes,
  input  logic              misoIn,
  output logic              sclk,
  output logic              halfTick,
  output logic              lastFall,
  output logic              sampleValid,
  output logic [DATA_W-1:0] sampleData
);

  localparam int HW = $clog2(HALF + 1);
  localparam int FW = $clog2(XFER_BITS + 1);

  logic [HW-1:0]        halfCnt;
  logic [FW-1:0]        fallCnt;
  logic [XFER_BITS-1:0] shiftReg;
  logic                 fallEdge;

  assign halfTick = strobes.runDiv && (halfCnt == HW'(HALF - 1));
  assign fallEdge = strobes.clkEn && halfTick && sclk;
  assign lastFall = fallEdge && (fallCnt == FW'(XFER_BITS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               halfCnt <= '0;
    else if (!strobes.runDiv) halfCnt <= '0;
    else if (halfTick)        halfCnt <= '0;
    else                      halfCnt <= halfCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk     <= 1'b0;
      fallCnt  <= '0;
      shiftReg <= '0;
    end else if (strobes.clear) begin
      sclk    <= 1'b0;
      fallCnt <= '0;
    end else begin
      if (strobes.clkEn && halfTick) sclk <= ~sclk;
      if (fallEdge) begin
        fallCnt  <= fallCnt + 1'b1;
        shiftReg <= {shiftReg[XFER_BITS-2:0], misoIn};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sampleValid <= 1'b0;
      sampleData  <= '0;
    end else begin
      sampleValid <= strobes.publish;
      if (strobes.publish) sampleData <= shiftReg[XFER_BITS-1 -: DATA_W];
    end
  end

  // R8: result strobe lasts one cycle
  p_valid_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sampleValid |=> !sampleValid);

  // R5: never more falling edges than the frame holds
  p_fall_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fallCnt <= FW'(XFER_BITS));

  // R4: the clock holds still unless the controller allows it
  p_sclk_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobes.clkEn && !strobes.clear) |=> $stable(sclk));

endmodule

// File: rtl/conv_readout_seq.sv
module conv_readout_seq
  import seq_pkg::*;
#(
  parameter int SYS_CLK_HZ    = 100_000_000,
  parameter int SCLK_MAX_HZ   = 17_000_000,
  parameter int SCLK_HALF_REQ = 1,
  parameter int TIMER_PERIOD  = 1000,
  parameter int CONV_PULSE_W  = 2,
  parameter int DATA_W        = 18,
  parameter int XFER_BITS     = 24,
  parameter int OVR_W         = 8,
  parameter bit IRQ_ENABLE    = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busyIn,
  input  logic              misoIn,
  output logic              convStart,
  output logic              csN,
  output logic              sclk,
  output logic              sampleValid,
  output logic [DATA_W-1:0] sampleData,
  output logic              irqStrobe,
  output logic [OVR_W-1:0]  overrunCount
);

  localparam int MIN_HALF = (SYS_CLK_HZ + 2 * SCLK_MAX_HZ - 1) / (2 * SCLK_MAX_HZ);
  localparam int HALF     = (SCLK_HALF_REQ < MIN_HALF) ? MIN_HALF : SCLK_HALF_REQ;

  dpCtrl_t strobes;
  logic    halfTick;
  logic    lastFall;

  seq_ctrl #(
    .TIMER_PERIOD(TIMER_PERIOD),
    .CONV_PULSE_W(CONV_PULSE_W),
    .OVR_W       (OVR_W)
  ) i_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .busyIn      (busyIn),
    .halfTick    (halfTick),
    .lastFall    (lastFall),
    .convStart   (convStart),
    .csN         (csN),
    .strobes     (strobes),
    .overrunCount(overrunCount)
  );

  seq_datapath #(
    .XFER_BITS(XFER_BITS),
    .DATA_W   (DATA_W),
    .HALF     (HALF)
  ) i_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobes    (strobes),
    .misoIn     (misoIn),
    .sclk       (sclk),
    .halfTick   (halfTick),
    .lastFall   (lastFall),
    .sampleValid(sampleValid),
    .sampleData (sampleData)
  );

  generate
    if (IRQ_ENABLE) begin : g_irq
      assign irqStrobe = sampleValid;
    end else begin : g_no_irq
      assign irqStrobe = 1'b0;
    end
  endgenerate

  // R4: clock rests low while deselected
  p_sclk_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    csN |-> !sclk);

endmodule

// File: tb/test_conv_readout_seq.sv
module test_conv_readout_seq;

  localparam int CLK_PERIOD = 10;
  localparam int PERIOD     = 400;
  localparam int EXP_HALF   = 3;   // ceil(100e6 / 34e6)
  localparam int CONV_W     = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        busyIn;
  logic        misoIn = 1'b0;
  logic        convStart, csN, sclk, sampleValid, irqStrobe;
  logic [17:0] sampleData;
  logic [7:0]  overrunCount;

  logic        busyModel = 1'b0;
  logic        forceBusy = 1'b0;
  logic [23:0] frame = '0;
  int          busyLen = 40;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  // monitor state
  int  cyc = 0, bCnt = 0;
  int  convRise = 0, convRisePrev = 0, curWidth = 0, lastWidth = 0;
  int  busyFallCyc = 0, csFallCyc = 0, csRiseCyc = 0;
  int  firstRiseCyc = 0, lastFallCyc = 0, lastToggle = 0, riseCnt = 0;
  int  widthErr = 0, idleErr = 0, wideErr = 0, validCnt = 0, validCyc = 0;
  int  bitIdx = 0;
  logic [17:0] capData = '0;
  logic capIrq = 1'b0;
  logic convPrev = 1'b0, csPrev = 1'b1, sclkPrev = 1'b0, validPrev = 1'b0;

  assign busyIn = busyModel | forceBusy;

  always #(CLK_PERIOD/2) clk = ~clk;

  conv_readout_seq #(.TIMER_PERIOD(PERIOD)) i_conv_readout_seq (
    .clk(clk), .rst_n(rst_n), .busyIn(busyIn), .misoIn(misoIn),
    .convStart(convStart), .csN(csN), .sclk(sclk),
    .sampleValid(sampleValid), .sampleData(sampleData),
    .irqStrobe(irqStrobe), .overrunCount(overrunCount)
  );

  // converter serial output: shifts on rising sclk, MSB first
  always @(posedge sclk or negedge csN) begin
    if (!sclk) bitIdx = 0;
    else if (!csN) begin
      if (bitIdx < 24) misoIn <= frame[23 - bitIdx];
      bitIdx = bitIdx + 1;
    end
  end

  // converter busy model and port monitor
  always @(negedge clk) begin
    logic newBusy;
    cyc = cyc + 1;
    if (convStart && !convPrev) begin
      convRisePrev = convRise; convRise = cyc; bCnt = busyLen + 2; curWidth = 0;
    end
    if (convStart) curWidth = curWidth + 1;
    if (!convStart && convPrev) lastWidth = curWidth;
    convPrev = convStart;
    newBusy = 1'b0;
    if (bCnt > 0) begin
      bCnt = bCnt - 1;
      newBusy = (bCnt > 0) && (bCnt <= busyLen);
    end
    if (busyModel && !newBusy) busyFallCyc = cyc;
    busyModel = newBusy;

    if (!csN && csPrev) begin csFallCyc = cyc; riseCnt = 0; end
    if (csN && !csPrev) csRiseCyc = cyc;
    if (sclk && !sclkPrev) begin
      if (riseCnt == 0) firstRiseCyc = cyc;
      else if (cyc - lastToggle != EXP_HALF) widthErr = widthErr + 1;
      riseCnt = riseCnt + 1; lastToggle = cyc;
    end
    if (!sclk && sclkPrev) begin
      if (cyc - lastToggle != EXP_HALF) widthErr = widthErr + 1;
      lastToggle = cyc; lastFallCyc = cyc;
    end
    if (csN && sclk) idleErr = idleErr + 1;
    if (sampleValid && validPrev) wideErr = wideErr + 1;
    if (sampleValid) begin
      validCnt = validCnt + 1; capData = sampleData; capIrq = irqStrobe; validCyc = cyc;
    end
    csPrev = csN; sclkPrev = sclk; validPrev = sampleValid;
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check("R1 csN", int'(csN), 1);
    check("R1 sclk", int'(sclk), 0);
    check("R1 convStart", int'(convStart), 0);
    check("R1 sampleValid", int'(sampleValid), 0);
    check("R1 irqStrobe", int'(irqStrobe), 0);
    check("R1 overrunCount", int'(overrunCount), 0);
  endtask

  task automatic t_frame(logic [17:0] word, logic [5:0] trail, int blen,
                         int expInterval, int expOvr);
    int n;
    frame = {word, trail};
    busyLen = blen;
    n = validCnt;
    while (validCnt == n) @(negedge clk);
    @(negedge clk);
    check("R6 data", int'(capData), int'(word));
    check("R8 irq", int'(capIrq), 1);
    check("R8 single cycle", wideErr, 0);
    check("R8 valid after csN", validCyc - csRiseCyc, 1);
    check("R5 rising edges", riseCnt, 24);
    check("R5 lead", firstRiseCyc - csFallCyc, EXP_HALF);
    check("R7 tail", csRiseCyc - lastFallCyc, EXP_HALF);
    check("R4 phase width", widthErr, 0);
    check("R4 idle low", idleErr, 0);
    check("R10 sync delay", csFallCyc - busyFallCyc, 3);
    check("R2 pulse width", lastWidth, CONV_W);
    if (expInterval > 0) check("R2 R9 interval", convRise - convRisePrev, expInterval);
    check("R9 overrun", int'(overrunCount), expOvr);
  endtask

  task automatic t_spurious();
    int n, lowSeen;
    n = validCnt;
    lowSeen = 0;
    forceBusy = 1'b1;
    repeat (6) @(negedge clk);
    forceBusy = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (!csN) lowSeen++;
    end
    check("R3 csN stays high", lowSeen, 0);
    check("R3 no result", validCnt - n, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_frame(18'h2A5C3, 6'h3F, 40, 0, 0);
    t_frame(18'h3FFFF, 6'h00, 25, PERIOD, 0);
    t_spurious();
    t_frame(18'h00001, 6'h2A, 300, PERIOD, 1);
    t_frame(18'h20000, 6'h15, 30, 2 * PERIOD, 1);
    t_frame(18'h15555, 6'h2B, 50, PERIOD, 1);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule